// File: doc/BRIEF.md
# Retention-aware refresh slot scheduler

This block sits in a memory controller next to the command arbiter and makes one decision per refresh interval for a single rank. For each interval it reads a 2-bit retention code for the bin that the device's internal refresh counter will cover next. It then asks the arbiter for either a real auto-refresh or a dummy refresh. A dummy refresh only moves the device counter forward and refreshes no rows. The block keeps its own copy of that counter as a bin pointer. It also keeps a window index that advances each time the pointer wraps past the last bin.

A code k means the bin has to be refreshed once every k+1 retention windows. A bin is due in any window whose index is a multiple of k+1. The window index runs modulo 12, the least common multiple of the four possible periods, so every period stays exact across the wrap. Each decision is held on a request/grant handshake until the arbiter accepts it. Intervals that expire while a decision is still waiting are counted, so no slot is lost. The code table is filled through a one-entry-per-cycle write port and is sized for block RAM.

Top module: `refsk_scheduler`

## Requirements
- R1: After reset `slot_req` is low, `window_idx` is 0, and the first request names bin 0.
- R2: When every request is granted promptly, successive requests rise exactly INTERVAL clock cycles apart.
- R3: For a bin holding code k (0..3), the request is real (`slot_real`=1) when the current window index modulo (k+1) is 0, and dummy (`slot_real`=0) otherwise.
- R4: Requests name bins 0,1,…,BINS-1 in order and then wrap to 0. Each wrap increments `window_idx` modulo 12, and the pointer moves only on a granted request.
- R5: While `slot_req` is high and `slot_grant` is low, `slot_req`, `slot_real` and `slot_bin` stay unchanged. A request drops in the cycle after it is granted.
- R6: Intervals that expire while a request waits are owed, up to 2^OWE_W-1 of them. After the grant, each owed slot is issued back to back for the following bins with the correct kind.
- R7: A code written through the table port for a bin is used at the next lookup of that bin.
- R8: With four bins where bins 0 and 2 hold code 0 and bins 1 and 3 hold code 3, a window whose index is not a multiple of 4 gives the sequence real, dummy, real, dummy.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tbl_wr_en | input | 1 | Write one retention code |
| tbl_wr_bin | input | BIN_W | Bin address of the write |
| tbl_wr_code | input | 2 | Retention code: refresh every code+1 windows |
| slot_req | output | 1 | A slot decision is pending |
| slot_real | output | 1 | 1 = real auto-refresh, 0 = dummy refresh |
| slot_bin | output | BIN_W | Bin the pending slot covers |
| slot_grant | input | 1 | Arbiter accepts the pending slot |
| window_idx | output | 4 | Current retention window, modulo 12 |

## Verification
The hardest state to reach is a backlog of owed intervals. In that state several slot decisions must come out back to back, each still with the right kind, bin and window. The stimulus gets there by holding off the grant for more than three intervals, which forces several owed slots across a pointer wrap. The bench then checks that the released requests keep the bin sequence and the window arithmetic intact. A second sweep rewrites each bin's code at the moment that bin is granted, so that every code meets every window index modulo 12.

// File: rtl/refsk_pkg.sv
package refsk_pkg;
  localparam int WIN_MOD = 12;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_READ = 2'd1,
    ST_HOLD = 2'd2
  } refsk_state_t;

  // A bin with code k is due in windows whose index is a multiple of k+1.
  function automatic logic slot_due(input logic [1:0] code, input logic [3:0] win);
    case (code)
      2'd0:    slot_due = 1'b1;
      2'd1:    slot_due = (win[0] == 1'b0);
      2'd2:    slot_due = (win == 4'd0) || (win == 4'd3) || (win == 4'd6) || (win == 4'd9);
      default: slot_due = (win[1:0] == 2'b00);
    endcase
  endfunction
endpackage

// File: rtl/refsk_tick_gen.sv
module refsk_tick_gen #(
  parameter int INTERVAL = 64,
  localparam int CW = (INTERVAL > 1) ? $clog2(INTERVAL) : 1
) (
  input  logic clk,
  input  logic rst,
  output logic tick
);
  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst || tick) cnt <= '0;
    else             cnt <= cnt + 1'b1;
  end

  assign tick = (cnt == CW'(INTERVAL - 1));

  generate
    if (INTERVAL > 1) begin : g_gap
      assert_tick_gap_R2: assert property (@(posedge clk) disable iff (rst)
        tick |=> !tick);
    end
  endgenerate
endmodule

// File: rtl/refsk_code_mem.sv
module refsk_code_mem #(
  parameter int DEPTH = 64,
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic          clk,
  input  logic          wr_en,
  input  logic [AW-1:0] wr_addr,
  input  logic [1:0]    wr_data,
  input  logic [AW-1:0] rd_addr,
  output logic [1:0]    rd_data
);
  logic [1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (wr_en) mem[wr_addr] <= wr_data;
    rd_data <= mem[rd_addr];
  end

  always_ff @(posedge clk) begin
    if (wr_en) assert_wr_in_range_R7: assert (int'(wr_addr) < DEPTH);
  end
endmodule

// File: rtl/refsk_scheduler.sv
module refsk_scheduler
  import refsk_pkg::*;
#(
  parameter int BINS     = 64,
  parameter int INTERVAL = 64,
  parameter int OWE_W    = 3,
  localparam int BIN_W   = (BINS > 1) ? $clog2(BINS) : 1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             tbl_wr_en,
  input  logic [BIN_W-1:0] tbl_wr_bin,
  input  logic [1:0]       tbl_wr_code,
  output logic             slot_req,
  output logic             slot_real,
  output logic [BIN_W-1:0] slot_bin,
  input  logic             slot_grant,
  output logic [3:0]       window_idx
);
  refsk_state_t     state;
  logic             tick;
  logic             start;
  logic [OWE_W-1:0] owed;
  logic [BIN_W-1:0] ptr;
  logic [1:0]       rd_code;
  logic             granted;

  refsk_tick_gen #(.INTERVAL(INTERVAL)) u_tick (
    .clk (clk),
    .rst (rst),
    .tick(tick)
  );

  refsk_code_mem #(.DEPTH(BINS)) u_mem (
    .clk    (clk),
    .wr_en  (tbl_wr_en),
    .wr_addr(tbl_wr_bin),
    .wr_data(tbl_wr_code),
    .rd_addr(ptr),
    .rd_data(rd_code)
  );

  assign start   = (state == ST_IDLE) && (tick || (owed != '0));
  assign granted = slot_req && slot_grant;

  // Intervals that expire while a decision is outstanding.
  always_ff @(posedge clk) begin
    if (rst) owed <= '0;
    else if (tick && !start && (owed != '1)) owed <= owed + 1'b1;
    else if (!tick && start && (owed != '0)) owed <= owed - 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state      <= ST_IDLE;
      slot_req   <= 1'b0;
      slot_real  <= 1'b0;
      slot_bin   <= '0;
      ptr        <= '0;
      window_idx <= '0;
    end else begin
      case (state)
        ST_IDLE: if (start) state <= ST_READ;
        ST_READ: begin
          state     <= ST_HOLD;
          slot_req  <= 1'b1;
          slot_real <= slot_due(rd_code, window_idx);
          slot_bin  <= ptr;
        end
        default: if (granted) begin
          state    <= ST_IDLE;
          slot_req <= 1'b0;
          if (ptr == BIN_W'(BINS - 1)) begin
            ptr        <= '0;
            window_idx <= (window_idx == 4'(WIN_MOD - 1)) ? 4'd0 : window_idx + 4'd1;
          end else begin
            ptr <= ptr + 1'b1;
          end
        end
      endcase
    end
  end

  assert_req_stable_R5: assert property (@(posedge clk) disable iff (rst)
    (slot_req && !slot_grant) |=> (slot_req && $stable(slot_bin) && $stable(slot_real)));
  assert_req_drop_R5: assert property (@(posedge clk) disable iff (rst)
    granted |=> !slot_req);
  assert_ptr_on_grant_R4: assert property (@(posedge clk) disable iff (rst)
    !$stable(ptr) |-> $past(granted));
  assert_window_range_R4: assert property (@(posedge clk) disable iff (rst)
    window_idx < 4'(WIN_MOD));
  assert_code0_real_R3: assert property (@(posedge clk) disable iff (rst)
    ((state == ST_READ) && (rd_code == 2'd0)) |=> slot_real);
  assert_no_overflow_R6: assert property (@(posedge clk) disable iff (rst)
    !((owed == '1) && tick && !start));
endmodule

// File: tb/sim_refsk_scheduler.sv
module sim_refsk_scheduler;
  localparam int BINS = 4;
  localparam int INTERVAL = 6;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       tbl_wr_en = 1'b0;
  logic [1:0] tbl_wr_bin = '0;
  logic [1:0] tbl_wr_code = '0;
  logic       slot_req, slot_real, slot_grant;
  logic [1:0] slot_bin;
  logic [3:0] window_idx;

  int checks = 0;
  int errors = 0;
  int cyc = 0;
  bit done = 1'b0;

  int shadow [BINS];
  int ew = 0;
  int ep = 0;

  always #2.5 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  refsk_scheduler #(.BINS(BINS), .INTERVAL(INTERVAL), .OWE_W(3)) u0 (
    .clk(clk), .rst(rst), .tbl_wr_en(tbl_wr_en), .tbl_wr_bin(tbl_wr_bin),
    .tbl_wr_code(tbl_wr_code), .slot_req(slot_req), .slot_real(slot_real),
    .slot_bin(slot_bin), .slot_grant(slot_grant), .window_idx(window_idx)
  );

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d (cycle %0d)", req, act, exp, cyc);
    end
  endtask

  // Write one code at a negedge; lands on the following posedge.
  task automatic wr_code(input int b, input int c);
    tbl_wr_en = 1'b1; tbl_wr_bin = 2'(b); tbl_wr_code = 2'(c); shadow[b] = c;
    @(negedge clk);
    tbl_wr_en = 1'b0;
  endtask

  task automatic wait_req(output int rise);
    while (!slot_req) @(negedge clk);
    rise = cyc;
  endtask

  // Check the pending request against the model, grant after 'hold' cycles,
  // optionally writing a new code for the granted bin in the grant cycle.
  task automatic serve(input string tag, input int hold, input bit do_wr, input int new_code);
    int exp_real;
    exp_real = ((ew % (shadow[ep] + 1)) == 0) ? 1 : 0;
    chk({tag, "/R3"}, int'(slot_real), exp_real);
    chk("R4 bin", int'(slot_bin), ep);
    chk("R4 window", int'(window_idx), ew);
    for (int h = 0; h < hold; h++) begin
      @(negedge clk);
      chk("R5 held", int'(slot_req), 1);
      chk("R5 bin", int'(slot_bin), ep);
      chk("R5 kind", int'(slot_real), exp_real);
    end
    slot_grant = 1'b1;
    if (do_wr) begin
      tbl_wr_en = 1'b1; tbl_wr_bin = 2'(ep); tbl_wr_code = 2'(new_code);
      shadow[ep] = new_code;
    end
    @(negedge clk);
    slot_grant = 1'b0;
    tbl_wr_en = 1'b0;
    chk("R5 drop", int'(slot_req), 0);
    ep = ep + 1;
    if (ep == BINS) begin
      ep = 0;
      ew = (ew + 1) % 12;
    end
  endtask

  initial begin
    int rise, prev_rise;
    slot_grant = 1'b0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    // R1: state right after reset.
    chk("R1 req", int'(slot_req), 0);
    chk("R1 window", int'(window_idx), 0);
    // R8 case: weak rows 7 and 20 fall in bins 0 and 2; the rest every 4 windows.
    wr_code(0, 0); wr_code(1, 3); wr_code(2, 0); wr_code(3, 3);
    wait_req(rise);
    chk("R1 first bin", int'(slot_bin), 0);
    prev_rise = -1;
    // Phase A: prompt grants, 8 windows.
    for (int s = 0; s < 8 * BINS; s++) begin
      wait_req(rise);
      if (prev_rise >= 0) chk("R2 spacing", rise - prev_rise, INTERVAL);
      prev_rise = rise;
      if ((ew % 4) != 0) chk("R8 sequence", int'(slot_real), ((ep % 2) == 0) ? 1 : 0);
      serve("R8", 0, 1'b0, 0);
    end
    // Phase B: codes rewritten at each grant (R7), delays 0..2, 24 windows.
    for (int s = 0; s < 24 * BINS; s++) begin
      int nxt;
      wait_req(rise);
      nxt = (ep + (s / BINS) + ((s / BINS) * ep) / 2) % 4;
      serve("R7", s % 3, 1'b1, nxt);
    end
    // Phase C: hold the grant over several intervals, then drain (R6).
    wait_req(rise);
    serve("R6", 3 * INTERVAL + 2, 1'b0, 0);
    for (int s = 0; s < 3; s++) begin
      @(negedge clk); @(negedge clk);
      chk("R6 owed slot ready", int'(slot_req), 1);
      wait_req(rise);
      serve("R6", 0, 1'b0, 0);
    end
    for (int s = 0; s < 2 * BINS; s++) begin
      wait_req(rise);
      serve("R6", 1, 1'b0, 0);
    end
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule